// File: doc/BRIEF.md
# Unaligned Byte-Write Word Packer

This block takes a byte-granular write request, given as a start byte address, a byte count and a stream of data bytes, and turns it into a sequence of aligned 32-bit word program requests for a NOR flash programmer downstream. Flash cells erase to all ones and programming can only clear bits. Every byte lane that carries no data is therefore driven to 0xFF, which leaves the stored byte as it is. No read-modify-write takes place.

A request is accepted in the idle state. Data bytes are then pulled one at a time into a word buffer. When the buffer holds a full word, or the data runs out, the word is offered to the programmer. The block waits for the programmer's response before it gathers the next word. A failed response ends the transfer at once. When the transfer ends, a one-cycle completion pulse is raised together with an error flag and the number of data bytes that were programmed successfully.

Top module: `wp_top`

## Requirements
- R1: Every word request carries an address with bits 1:0 at zero. The first word of a transfer goes to the start address with its two low bits cleared.
- R2: In the first word of a transfer that starts at byte offset k = addr[1:0], lanes below k hold 0xFF. Lane i occupies bits 8i+7:8i.
- R3: In the first word, data bytes fill lanes upward from k in stream order. If the data runs out before lane 3, the lanes above the last data byte hold 0xFF.
- R4: Each word after the first goes to the previous address plus 4. A word that holds four data bytes carries them unchanged, with the earliest byte in lane 0.
- R5: A final word with fewer than four data bytes holds them in the lowest lanes and 0xFF in the remaining lanes.
- R6: A request of length zero issues no word. The completion pulse follows in the next cycle with the error flag clear and a byte count of 0.
- R7: An error response to a word ends the transfer. No further word is issued, and the completion pulse follows with the error flag set.
- R8: The byte count starts at 0 for each request. It grows only by the number of data bytes in each word that completes without error, never by padding bytes.
- R9: While a word request is offered and not accepted, its address and data stay unchanged.
- R10: No stream byte is accepted while a word is offered or awaiting its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Number of data bytes |
| in_valid | input | 1 | Data byte present |
| in_ready | output | 1 | Block takes a data byte |
| in_data | input | 8 | Data byte |
| wr_valid | output | 1 | Word program request offered |
| wr_ready | input | 1 | Programmer accepts the word |
| wr_addr | output | ADDR_W | Aligned word address |
| wr_data | output | 32 | Word data, lane 0 in bits 7:0 |
| rsp_valid | input | 1 | Programmer result for the accepted word |
| rsp_err | input | 1 | Result is a failure |
| done | output | 1 | One-cycle end-of-transfer pulse |
| done_err | output | 1 | Transfer ended on an error |
| byte_count | output | LEN_W | Data bytes programmed successfully |

## Verification
The transfers exercised are an aligned whole-word transfer, single-byte and two-byte transfers that sit inside one word at a non-zero offset, a long unaligned transfer with head, body and tail words, and a zero-length request. Together they separate the padding below the start, the padding above the data, the unchanged body words and the tail padding. An error on the first word and an error in mid-transfer test that no further word is issued and that the byte count covers only the completed words. A run with a programmer that stalls on alternate cycles tests that the offered word stays unchanged and that no byte is taken while a word is pending.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int WORD_BYTES = 4;
  localparam int LANE_W     = $clog2(WORD_BYTES);
  localparam int WORD_W     = 8 * WORD_BYTES;

  typedef enum logic [2:0] {
    S_IDLE, S_FILL, S_SEND, S_WAIT, S_DONE
  } wp_state_e;

  // Last byte of a word: either the top lane is reached or data runs out.
  function automatic logic word_closes(input logic [LANE_W-1:0] lane,
                                       input logic               last_byte);
    return (lane == LANE_W'(WORD_BYTES - 1)) || last_byte;
  endfunction

  // Padding value for an unwritten flash byte.
  function automatic logic [7:0] erased_byte();
    return 8'hFF;
  endfunction
endpackage

// File: rtl/wp_lane_buf.sv
module wp_lane_buf
  import wp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [LANE_W-1:0] lane,
  input  logic [7:0]        byte_in,
  output logic [WORD_W-1:0] word
);
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   lane_q <= erased_byte();
      else if (clear)                               lane_q <= erased_byte();
      else if (load && (lane == LANE_W'(g)))        lane_q <= byte_in;
    end
    assign word[8*g +: 8] = lane_q;
  end
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  output logic              done,
  output logic              done_err,
  output logic [LEN_W-1:0]  byte_count,
  output logic              buf_clear,
  output logic              buf_load,
  output logic [LANE_W-1:0] lane,
  output logic              ev_start,
  output logic              ev_word_resp
);
  wp_state_e         st;
  logic [ADDR_W-1:0] waddr;
  logic [LEN_W-1:0]  left;
  logic [LANE_W:0]   nbytes;
  logic [LEN_W-1:0]  count;
  logic              err;

  assign req_ready    = (st == S_IDLE);
  assign in_ready     = (st == S_FILL);
  assign wr_valid     = (st == S_SEND);
  assign wr_addr      = waddr;
  assign done         = (st == S_DONE);
  assign done_err     = err;
  assign byte_count   = count;
  assign ev_start     = req_valid && req_ready;
  assign ev_word_resp = rsp_valid && (st == S_WAIT);
  assign buf_load     = in_valid && in_ready;
  assign buf_clear    = ev_start || (ev_word_resp && !rsp_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      waddr  <= '0;
      left   <= '0;
      lane   <= '0;
      nbytes <= '0;
      count  <= '0;
      err    <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          waddr  <= {req_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
          lane   <= req_addr[LANE_W-1:0];
          left   <= req_len;
          nbytes <= '0;
          count  <= '0;
          err    <= 1'b0;
          st     <= (req_len == '0) ? S_DONE : S_FILL;
        end
        S_FILL: if (in_valid) begin
          left   <= left - 1'b1;
          nbytes <= nbytes + 1'b1;
          lane   <= lane + 1'b1;
          if (word_closes(lane, left == LEN_W'(1))) st <= S_SEND;
        end
        S_SEND: if (wr_ready) st <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (rsp_err) begin
            err <= 1'b1;
            st  <= S_DONE;
          end else begin
            count  <= count + LEN_W'(nbytes);
            nbytes <= '0;
            lane   <= '0;
            waddr  <= waddr + ADDR_W'(WORD_BYTES);
            st     <= (left == '0) ? S_DONE : S_FILL;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wp_top.sv
module wp_top
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  output logic              done,
  output logic              done_err,
  output logic [LEN_W-1:0]  byte_count
);
  logic              buf_clear;
  logic              buf_load;
  logic [LANE_W-1:0] lane;
  logic              ev_start;
  logic              ev_word_resp;

  wp_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk, .rst_n,
    .req_valid, .req_ready, .req_addr, .req_len,
    .in_valid, .in_ready,
    .wr_valid, .wr_ready, .wr_addr,
    .rsp_valid, .rsp_err,
    .done, .done_err, .byte_count,
    .buf_clear, .buf_load, .lane,
    .ev_start, .ev_word_resp
  );

  wp_lane_buf u_buf (
    .clk, .rst_n,
    .clear(buf_clear), .load(buf_load), .lane,
    .byte_in(in_data), .word(wr_data)
  );
endmodule

// File: rtl/wp_checker.sv
module wp_checker
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LEN_W-1:0]  req_len,
  input logic              in_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic              rsp_err,
  input logic              done,
  input logic              done_err,
  input logic [LEN_W-1:0]  byte_count,
  input logic              ev_start,
  input logic              ev_word_resp
);
  a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[LANE_W-1:0] == '0));

  a_r9_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  a_r10_no_byte_while_word: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && wr_valid));

  a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len == '0)) |=> (done && !done_err && (byte_count == '0)));

  a_r7_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_word_resp && rsp_err) |=> (done && done_err && !wr_valid));

  a_r8_error_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_word_resp && rsp_err) |=> $stable(byte_count));

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_start |=> ((byte_count - $past(byte_count)) <= LEN_W'(WORD_BYTES)));
endmodule

bind wp_top wp_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_wp_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_len(req_len), .in_ready(in_ready), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .rsp_err(rsp_err), .done(done), .done_err(done_err),
  .byte_count(byte_count), .ev_start(ev_start), .ev_word_resp(ev_word_resp)
);

// File: tb/tb_wp_top.sv
module tb_wp_top;
  localparam int AW = 32;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = '0;
  logic          wr_valid;
  logic          wr_ready = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic          rsp_valid = 1'b0;
  logic          rsp_err = 1'b0;
  logic          done;
  logic          done_err;
  logic [LW-1:0] byte_count;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wp_top #(.ADDR_W(AW), .LEN_W(LW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run(input int a, input int len, input int fail_at, input bit stall, input int seed);
    logic [7:0] bq[$];
    int wa[$];
    logic [31:0] wd[$];
    int wn[$];
    int pos, off, base, issued, exp_cnt, widx, cyc;
    bit fin, pend, held;
    logic [31:0] hd;
    logic [AW-1:0] ha;
    logic [31:0] d;
    int n;
    for (int i = 0; i < len; i++) bq.push_back(8'((seed * 37 + i * 13 + 5) & 255));
    // behavioural word list
    pos = 0; off = a % 4; base = a - off;
    while (pos < len) begin
      d = 32'hFFFF_FFFF; n = 0;
      for (int l = off; l < 4 && pos < len; l++) begin
        d[8*l +: 8] = bq[pos]; pos++; n++;
      end
      wa.push_back(base); wd.push_back(d); wn.push_back(n);
      base += 4; off = 0;
    end
    issued = (fail_at >= 0 && fail_at < wa.size()) ? fail_at + 1 : wa.size();
    exp_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(a); req_len = LW'(len);
    @(negedge clk);
    req_valid = 1'b0;
    widx = 0; fin = 0; pend = 0; held = 0; cyc = 0;
    while (!fin && cyc < 4000) begin
      rsp_valid = pend;
      rsp_err   = pend && ((widx - 1) == fail_at);
      pend      = 0;
      in_valid  = (bq.size() > 0);
      in_data   = (bq.size() > 0) ? bq[0] : 8'h00;
      wr_ready  = stall ? cyc[0] : 1'b1;
      #1;
      chk(!(in_ready && wr_valid), "R10 byte taken while word pending", in_ready, 0);
      if (held) chk(wr_valid && wr_addr == ha && wr_data == hd, "R9 held word changed", wr_data, hd);
      held = 0;
      if (done) begin
        chk(done_err == (fail_at >= 0 && fail_at < wa.size()), "R7 error flag", done_err, fail_at >= 0);
        chk(byte_count == LW'(exp_cnt), "R8 byte count", byte_count, exp_cnt);
        chk(widx == issued, "R7 R6 words issued", widx, issued);
        fin = 1;
      end else begin
        if (in_valid && in_ready) void'(bq.pop_front());
        if (wr_valid && !wr_ready) begin held = 1; ha = wr_addr; hd = wr_data; end
        if (wr_valid && wr_ready) begin
          if (widx >= wa.size()) chk(0, "R7 R6 extra word", widx, wa.size());
          else begin
            chk(wr_addr == AW'(wa[widx]), "R1 R4 word address", wr_addr, wa[widx]);
            if (widx == 0 && (a % 4) != 0)      chk(wr_data == wd[widx], "R2 R3 head word", wr_data, wd[widx]);
            else if (wn[widx] < 4)               chk(wr_data == wd[widx], "R5 tail word", wr_data, wd[widx]);
            else                                 chk(wr_data == wd[widx], "R4 full word", wr_data, wd[widx]);
            if (widx != fail_at) exp_cnt += wn[widx];
          end
          widx++; pend = 1;
        end
      end
      @(negedge clk);
      cyc++;
    end
    if (!fin) chk(0, "R7 transfer never completed", 0, 1);
    in_valid = 0; rsp_valid = 0; rsp_err = 0; wr_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !wr_valid && !done && byte_count == 0, "R8 reset state", byte_count, 0);
    run(32'h100, 8, -1, 0, 1);   // aligned, two full words (R4)
    run(32'h203, 1, -1, 0, 2);   // single byte in lane 3 (R2)
    run(32'h201, 2, -1, 0, 3);   // lanes 1..2, lanes 0 and 3 padded (R3)
    run(32'h302, 11, -1, 0, 4);  // head, body, tail (R5)
    run(32'h380, 0, -1, 0, 5);   // zero length (R6)
    run(32'h400, 12, 1, 0, 6);   // error on second word (R7)
    run(32'h501, 9, -1, 1, 7);   // stalling programmer (R9, R10)
    run(32'h603, 6, 0, 0, 8);    // error on first word (R8)
    run(32'h700, 3, -1, 1, 9);   // short aligned tail only (R5)
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule